// File: doc/BRIEF.md
# Serial Controller External FIFO Bridge

This block sits between a host bus and a serial communications controller with two channels. It holds one external transmit FIFO and one external receive FIFO, both attached to channel A. It also holds a FIFO control register and a read-only FIFO status register. When the FIFOs are switched on, host accesses to channel A's data port are redirected into the FIFOs. Control-port accesses to either channel always pass through to the controller, and so does channel B's data port.

The controller side has three parts. A register port carries request, write flag, channel, register index and data. A transmit byte stream uses a valid/ready handshake. A receive byte stream arrives on a valid strobe. Control-port access takes two steps. A pointer state machine for each channel has the states `PTR_IDLE` and `PTR_ARMED`. A write in `PTR_IDLE` stores a register index and takes transition *select* to `PTR_ARMED`. The next access reaches that register and takes transition *complete* back to `PTR_IDLE`.

A mode state machine has the states `MODE_OFF` and `MODE_ON`. Writing the enable bit as 1 takes transition *enable* to `MODE_ON`; writing it as 0 takes transition *disable* back to `MODE_OFF`. A power-up reset or a card-insert reset pulse takes transition *force_off*. It also returns both pointer machines to `PTR_IDLE`.

Top module: `sccfifo_bridge`

Host addresses: 0 = channel A control, 1 = channel A data, 2 = channel B control, 3 = channel B data, 4 = FIFO control, 5 = FIFO status. Any other address reads 0x00.

The FIFO control register has three bits:
- bit 0: enable
- bit 1: transmit FIFO reset
- bit 2: receive FIFO reset

Bits 7:3 read 0.

The FIFO status register has these bits:
- bit 0: transmit empty
- bit 1: transmit full
- bit 2: transmit at least half full
- bit 3: receive empty
- bit 4: receive full
- bit 5: receive at least half full
- bit 6: sticky receive overrun
- bit 7: reads 0

The controller answers register reads on `scc_rdata` in the same cycle as the request.

## Requirements
- R1: After `rst_n` low, or the cycle after a `card_rst` pulse, the mode is off, both FIFOs are empty and the overrun flag is clear. The control register then reads 0x00 and the status register reads 0x09.
- R2: A control write accepted while off, with bit 0 = 0 and bit 1 (or bit 2) = 1, empties the transmit (or receive) FIFO by the next cycle. The bit then reads back as 1 and holds that FIFO cleared until a later write sets it to 0. An accepted receive reset also clears the overrun flag.
- R3: A reset bit written while the mode is on, or in a write that also sets bit 0, is ignored. FIFO contents stay unchanged and the reset bit reads back as 0.
- R4: The status bits follow the layout above, with half-full meaning 8 or more of the 16 entries. Empty and full are never both set for the same FIFO.
- R5: A control-port write in `PTR_IDLE` reaches no controller register; it stores `host_wdata[3:0]` as the index. The next control-port access on that channel is forwarded with that index, and the pointer then returns to `PTR_IDLE`. A control-port read in `PTR_IDLE` is forwarded to register 0.
- R6: Control-port accesses of both channels are forwarded to the controller whether the mode is on or off.
- R7: While on, a write to address 1 pushes into the transmit FIFO without any controller request. A write to a full transmit FIFO is dropped.
- R8: While on, a read of address 1 pops the receive FIFO head and makes no controller request. A read of an empty receive FIFO returns 0x00 and changes nothing.
- R9: A data-port access of channel B, or of channel A while off, is forwarded to the controller as register 8 of that channel.
- R10: Register 8 reached through a control port is forwarded to the controller and leaves the FIFO status unchanged.
- R11: While on and the transmit FIFO is not empty, `tx_valid` is 1 and `tx_data` shows the oldest byte. The byte is removed on a cycle with `tx_ready` high. While off, `tx_valid` is 0.
- R12: While on, a receive byte with `rx_valid` is pushed if the receive FIFO is not full. Otherwise it sets the sticky overrun bit 6, which holds until a receive reset. While off, `rx_valid` is ignored.
- R13: Accesses to the FIFO control and status registers never make a controller request, so FIFO resets leave the controller's own buffers untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| card_rst | input | 1 | Synchronous card-insert reset, active high |
| host_sel | input | 1 | Host access in this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, same cycle |
| scc_req | output | 1 | Controller register access |
| scc_wr | output | 1 | Controller access is a write |
| scc_chan | output | 1 | Controller channel, 0 = A |
| scc_reg | output | 4 | Controller register index |
| scc_wdata | output | 8 | Controller write data |
| scc_rdata | input | 8 | Controller read data |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Controller accepts transmit byte |
| rx_valid | input | 1 | Receive byte strobe |
| rx_data | input | 8 | Receive byte |

## Verification
The transmit path is filled past capacity while the handshake is stalled, then drained in bursts. The scoreboard shows whether the 17th byte was dropped and whether the order was kept. The receive path gets 20 back-to-back bytes, so in-order pops can be told apart from overrun counting, and an extra read probes the empty-read value. Reset writes are issued in both modes, and data-port accesses are repeated off and on on both channels, which separates redirection from pass-through. Control-port sequences cover a read in the idle pointer state, an index write followed by an access, and register 8, which shows whether the pointer returns to idle.

// File: rtl/sccb_pkg.sv
package sccb_pkg;

    typedef enum logic {
        PTR_IDLE,
        PTR_ARMED
    } ptr_state_e;

    typedef enum logic {
        MODE_OFF,
        MODE_ON
    } mode_state_e;

    // controller register index that holds the channel data buffer
    localparam int DATA_REG_IDX = 8;

    // FIFO control register bit positions
    localparam int FC_EN    = 0;
    localparam int FC_TXRST = 1;
    localparam int FC_RXRST = 2;

endpackage

// File: rtl/sccb_fifo.sv
module sccb_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic             half
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;
    logic             push_ok, pop_ok;

    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wp_q <= wp_q + AW'(1);
            if (pop_ok)  rp_q <= rp_q + AW'(1);
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wp_q] <= din;
    end

    assign dout  = mem[rp_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));
    assign half  = (cnt_q >= CW'(DEPTH / 2));

endmodule

// File: rtl/sccb_ptr_fsm.sv
module sccb_ptr_fsm
    import sccb_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_clr,
    input  logic          acc,
    input  logic          wr,
    input  logic [IW-1:0] idx_in,
    output logic          fwd,
    output logic [IW-1:0] fwd_idx
);
    ptr_state_e    state_q, state_nxt;
    logic [IW-1:0] idx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PTR_IDLE;
            idx_q   <= '0;
        end else if (sync_clr) begin
            state_q <= PTR_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_nxt;
            if (state_q == PTR_IDLE && acc && wr) idx_q <= idx_in;
        end
    end

    // transitions: select (IDLE->ARMED), complete (ARMED->IDLE)
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            PTR_IDLE:  if (acc && wr) state_nxt = PTR_ARMED;
            PTR_ARMED: if (acc)       state_nxt = PTR_IDLE;
            default:   state_nxt = PTR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fwd     = 1'b0;
        fwd_idx = '0;
        unique case (state_q)
            PTR_IDLE:  fwd = acc && !wr;
            PTR_ARMED: begin
                fwd     = acc;
                fwd_idx = idx_q;
            end
            default:   fwd = 1'b0;
        endcase
    end

endmodule

// File: rtl/sccfifo_bridge.sv
module sccfifo_bridge
    import sccb_pkg::*;
#(
    parameter int NCH     = 2,
    parameter int DW      = 8,
    parameter int IW      = 4,
    parameter int DEPTH   = 16,
    parameter int FIFO_CH = 0,
    parameter int HAW     = $clog2(2 * NCH + 2),
    parameter int CHW     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           card_rst,
    input  logic           host_sel,
    input  logic           host_wr,
    input  logic [HAW-1:0] host_addr,
    input  logic [DW-1:0]  host_wdata,
    output logic [DW-1:0]  host_rdata,
    output logic           scc_req,
    output logic           scc_wr,
    output logic [CHW-1:0] scc_chan,
    output logic [IW-1:0]  scc_reg,
    output logic [DW-1:0]  scc_wdata,
    input  logic [DW-1:0]  scc_rdata,
    output logic           tx_valid,
    output logic [DW-1:0]  tx_data,
    input  logic           tx_ready,
    input  logic           rx_valid,
    input  logic [DW-1:0]  rx_data
);
    localparam logic [HAW-1:0] A_FCR = HAW'(2 * NCH);
    localparam logic [HAW-1:0] A_FSR = HAW'(2 * NCH + 1);
    localparam logic [HAW-1:0] A_DAT_F = HAW'(2 * FIFO_CH + 1);

    // ---------------- control-port pointers ----------------
    logic [NCH-1:0] ctl_acc, ctl_fwd;
    logic [IW-1:0]  ctl_idx [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_ptr
        assign ctl_acc[c] = host_sel && (host_addr == HAW'(2 * c));
        sccb_ptr_fsm #(.IW(IW)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_clr (card_rst),
            .acc      (ctl_acc[c]),
            .wr       (host_wr),
            .idx_in   (host_wdata[IW-1:0]),
            .fwd      (ctl_fwd[c]),
            .fwd_idx  (ctl_idx[c])
        );
    end

    // ---------------- mode state machine ----------------
    mode_state_e mode_q, mode_nxt;
    logic        mode_on;
    logic        fcr_wr;
    logic        rst_accept;
    logic        tx_rst_q, rx_rst_q;
    logic        tx_clr, rx_clr;
    logic        ovr_q;

    assign fcr_wr = host_sel && host_wr && (host_addr == A_FCR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mode_q <= MODE_OFF;
        else if (card_rst) mode_q <= MODE_OFF;
        else               mode_q <= mode_nxt;
    end

    // transitions: enable (OFF->ON), disable (ON->OFF); force_off via resets
    always_comb begin
        mode_nxt = mode_q;
        unique case (mode_q)
            MODE_OFF: if (fcr_wr && host_wdata[FC_EN])  mode_nxt = MODE_ON;
            MODE_ON:  if (fcr_wr && !host_wdata[FC_EN]) mode_nxt = MODE_OFF;
            default:  mode_nxt = MODE_OFF;
        endcase
    end

    // outputs of the mode machine
    always_comb begin
        mode_on    = 1'b0;
        rst_accept = 1'b0;
        unique case (mode_q)
            MODE_OFF: rst_accept = fcr_wr && !host_wdata[FC_EN];
            MODE_ON:  mode_on    = 1'b1;
            default:  mode_on    = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_rst_q <= 1'b0;
            rx_rst_q <= 1'b0;
        end else if (card_rst) begin
            tx_rst_q <= 1'b0;
            rx_rst_q <= 1'b0;
        end else if (fcr_wr) begin
            tx_rst_q <= rst_accept && host_wdata[FC_TXRST];
            rx_rst_q <= rst_accept && host_wdata[FC_RXRST];
        end
    end

    assign tx_clr = card_rst || tx_rst_q || (rst_accept && host_wdata[FC_TXRST]);
    assign rx_clr = card_rst || rx_rst_q || (rst_accept && host_wdata[FC_RXRST]);

    // ---------------- FIFOs ----------------
    logic          tx_push, tx_pop, tx_empty, tx_full, tx_half;
    logic          rx_push, rx_pop, rx_empty, rx_full, rx_half;
    logic [DW-1:0] tx_dout, rx_dout;

    sccb_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_txf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_clr),
        .push  (tx_push),
        .pop   (tx_pop),
        .din   (host_wdata),
        .dout  (tx_dout),
        .empty (tx_empty),
        .full  (tx_full),
        .half  (tx_half)
    );

    sccb_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_rxf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .push  (rx_push),
        .pop   (rx_pop),
        .din   (rx_data),
        .dout  (rx_dout),
        .empty (rx_empty),
        .full  (rx_full),
        .half  (rx_half)
    );

    assign tx_valid = mode_on && !tx_empty;
    assign tx_data  = tx_dout;
    assign tx_pop   = tx_valid && tx_ready;
    assign rx_push  = mode_on && rx_valid && !rx_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          ovr_q <= 1'b0;
        else if (rx_clr)                     ovr_q <= 1'b0;
        else if (mode_on && rx_valid && rx_full) ovr_q <= 1'b1;
    end

    logic [DW-1:0] fsr_w, fcr_w;
    always_comb begin
        fsr_w    = '0;
        fsr_w[0] = tx_empty;
        fsr_w[1] = tx_full;
        fsr_w[2] = tx_half;
        fsr_w[3] = rx_empty;
        fsr_w[4] = rx_full;
        fsr_w[5] = rx_half;
        fsr_w[6] = ovr_q;
        fcr_w           = '0;
        fcr_w[FC_EN]    = mode_on;
        fcr_w[FC_TXRST] = tx_rst_q;
        fcr_w[FC_RXRST] = rx_rst_q;
    end

    // ---------------- host decode ----------------
    always_comb begin
        scc_req    = 1'b0;
        scc_wr     = 1'b0;
        scc_chan   = '0;
        scc_reg    = '0;
        scc_wdata  = host_wdata;
        host_rdata = '0;
        tx_push    = 1'b0;
        rx_pop     = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (ctl_fwd[c]) begin
                scc_req  = 1'b1;
                scc_wr   = host_wr;
                scc_chan = CHW'(c);
                scc_reg  = ctl_idx[c];
            end
            if (host_sel && host_addr == HAW'(2 * c + 1)) begin
                if (HAW'(2 * c + 1) == A_DAT_F && mode_on) begin
                    if (host_wr) begin
                        tx_push = !tx_full;
                    end else begin
                        rx_pop     = !rx_empty;
                        host_rdata = rx_empty ? '0 : rx_dout;
                    end
                end else begin
                    scc_req  = 1'b1;
                    scc_wr   = host_wr;
                    scc_chan = CHW'(c);
                    scc_reg  = IW'(DATA_REG_IDX);
                end
            end
        end
        if (host_sel && !host_wr) begin
            if (host_addr == A_FCR) host_rdata = fcr_w;
            if (host_addr == A_FSR) host_rdata = fsr_w;
        end
        if (scc_req && !scc_wr) host_rdata = scc_rdata;
    end

endmodule

// File: rtl/sccb_checker.sv
module sccb_checker #(
    parameter int HAW = 3,
    parameter int DW  = 8,
    parameter int NCH = 2,
    parameter int FIFO_CH = 0
) (
    input logic           clk,
    input logic           rst_n,
    input logic           card_rst,
    input logic           host_sel,
    input logic           host_wr,
    input logic [HAW-1:0] host_addr,
    input logic           wr_en_bit,
    input logic           wr_rxrst_bit,
    input logic           scc_req,
    input logic           tx_valid,
    input logic           tx_ready,
    input logic [DW-1:0]  tx_data,
    input logic           mode_on,
    input logic           tx_rst_q,
    input logic           rx_rst_q,
    input logic           st_tx_empty,
    input logic           st_tx_full,
    input logic           st_rx_empty,
    input logic           st_rx_full,
    input logic           st_ovr
);
    logic fcr_acc, fcr_write, regs_acc, fifo_data_acc, rx_reset_req;

    assign fcr_acc       = host_sel && (host_addr == HAW'(2 * NCH));
    assign fcr_write     = fcr_acc && host_wr;
    assign regs_acc      = fcr_acc || (host_sel && host_addr == HAW'(2 * NCH + 1));
    assign fifo_data_acc = host_sel && (host_addr == HAW'(2 * FIFO_CH + 1));
    assign rx_reset_req  = fcr_write && !mode_on && !wr_en_bit && wr_rxrst_bit;

    assert_card_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |=> (st_tx_empty && st_rx_empty && !st_ovr && !mode_on));

    assert_reset_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_write && (mode_on || wr_en_bit)) |=> (!tx_rst_q && !rx_rst_q));

    assert_no_empty_and_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_tx_empty && st_tx_full) && !(st_rx_empty && st_rx_full));

    assert_redirect_no_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_on && fifo_data_acc) |-> !scc_req);

    assert_tx_quiet_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_on |-> !tx_valid);

    assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !card_rst && !fcr_write) |=> (tx_valid && $stable(tx_data)));

    assert_overrun_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ovr && !card_rst && !rx_rst_q && !rx_reset_req) |=> st_ovr);

    assert_fifo_regs_local_R13: assert property (@(posedge clk) disable iff (!rst_n)
        regs_acc |-> !scc_req);

endmodule

bind sccfifo_bridge sccb_checker #(.HAW(HAW), .DW(DW), .NCH(NCH), .FIFO_CH(FIFO_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .card_rst     (card_rst),
    .host_sel     (host_sel),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .wr_en_bit    (host_wdata[0]),
    .wr_rxrst_bit (host_wdata[2]),
    .scc_req      (scc_req),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .mode_on      (mode_on),
    .tx_rst_q     (tx_rst_q),
    .rx_rst_q     (rx_rst_q),
    .st_tx_empty  (fsr_w[0]),
    .st_tx_full   (fsr_w[1]),
    .st_rx_empty  (fsr_w[3]),
    .st_rx_full   (fsr_w[4]),
    .st_ovr       (fsr_w[6])
);

// File: tb/sccfifo_bridge_tb.sv
module sccfifo_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam logic [2:0] A_CTL_A = 3'd0, A_DAT_A = 3'd1, A_CTL_B = 3'd2,
                           A_DAT_B = 3'd3, A_FCR = 3'd4, A_FSR = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n, card_rst, host_sel, host_wr;
    logic [2:0] host_addr;
    logic [7:0] host_wdata, host_rdata, scc_wdata, scc_rdata, tx_data, rx_data;
    logic       scc_req, scc_wr, scc_chan, tx_valid, tx_ready, rx_valid;
    logic [3:0] scc_reg;

    int n_tests = 0;
    int n_fail  = 0;
    int drained = 0;
    int txm = 0;
    int rxm = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    // controller register model: answers with channel and index
    assign scc_rdata = {3'b101, scc_chan, scc_reg};

    sccfifo_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst),
        .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .scc_req(scc_req), .scc_wr(scc_wr), .scc_chan(scc_chan),
        .scc_reg(scc_reg), .scc_wdata(scc_wdata), .scc_rdata(scc_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one host access; combinational results captured mid-cycle
    logic [7:0] a_rd;
    logic       a_rq, a_wr, a_ch;
    logic [3:0] a_rg;
    task automatic acc(input logic wr, input logic [2:0] a, input logic [7:0] d);
        host_sel = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
        #1;
        a_rd = host_rdata; a_rq = scc_req; a_wr = scc_wr; a_ch = scc_chan; a_rg = scc_reg;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic status_is(input string req, input logic [7:0] exp);
        acc(1'b0, A_FSR, 8'h00);
        chk(req, a_rd, exp);
    endtask

    // scoreboard driver: transmit pushes
    task automatic push_tx(input logic [7:0] d);
        acc(1'b1, A_DAT_A, d);
        if (txm < DEPTH) begin txq.push_back(d); txm++; end
    endtask

    // scoreboard driver: receive bytes
    task automatic send_rx(input logic [7:0] d, input logic on);
        rx_valid = 1'b1; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
        if (on && rxm < DEPTH) begin rxq.push_back(d); rxm++; end
    endtask

    // scoreboard monitor: transmit stream
    always @(negedge clk) begin
        #3;
        if (tx_valid && tx_ready) begin
            if (txq.size() == 0) chk("R11 unexpected tx byte", {24'h0, tx_data}, 32'hFFFF);
            else chk("R11 tx order", {24'h0, tx_data}, {24'h0, txq.pop_front()});
            drained++;
            txm--;
        end
    end

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        rst_n = 1'b0; card_rst = 1'b0; host_sel = 1'b0; host_wr = 1'b0;
        host_addr = '0; host_wdata = '0; tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        acc(1'b0, A_FCR, 8'h00);
        chk("R1 ctrl after reset", a_rd, 8'h00);
        chk("R13 ctrl read no request", a_rq, 1'b0);
        status_is("R1 status after reset", 8'h09);

        // R5 idle read goes to register 0
        acc(1'b0, A_CTL_A, 8'h00);
        chk("R5 idle read request", {a_rq, a_wr, a_ch, a_rg}, {1'b1, 1'b0, 1'b0, 4'd0});
        chk("R5 idle read data", a_rd, 8'hA0);
        // R5/R6 two-step write on channel B
        acc(1'b1, A_CTL_B, 8'h05);
        chk("R5 select write no request", a_rq, 1'b0);
        acc(1'b1, A_CTL_B, 8'h3C);
        chk("R6 channel B reg 5 write", {a_rq, a_wr, a_ch, a_rg}, {1'b1, 1'b1, 1'b1, 4'd5});
        acc(1'b0, A_CTL_B, 8'h00);
        chk("R5 pointer back to 0", {a_rq, a_ch, a_rg}, {1'b1, 1'b1, 4'd0});

        // R9 data port while off
        acc(1'b1, A_DAT_A, 8'h11);
        chk("R9 off data A write", {a_rq, a_wr, a_ch, a_rg}, {1'b1, 1'b1, 1'b0, 4'd8});
        status_is("R9 off write leaves FIFO", 8'h09);

        // enable
        acc(1'b1, A_FCR, 8'h01);
        acc(1'b0, A_FCR, 8'h00);
        chk("R1 ctrl enable readback", a_rd, 8'h01);
        acc(1'b0, A_CTL_A, 8'h00);
        chk("R6 control passes while on", {a_rq, a_rg}, {1'b1, 4'd0});

        // R7/R4 fill transmit FIFO, stalled
        for (int i = 0; i < 7; i++) push_tx(8'h40 + 8'(i));
        status_is("R4 seven entries", 8'h08);
        push_tx(8'h47);
        status_is("R4 half at eight", 8'h0C);
        for (int i = 8; i < 16; i++) begin
            push_tx(8'h40 + 8'(i));
            if (i == 15) chk("R7 redirected no request", a_rq, 1'b0);
        end
        status_is("R4 tx full", 8'h0E);
        push_tx(8'hEE);
        status_is("R7 overflow dropped", 8'h0E);

        // R3 reset refused while on
        acc(1'b1, A_FCR, 8'h03);
        acc(1'b0, A_FCR, 8'h00);
        chk("R3 reset bit reads 0", a_rd, 8'h01);
        status_is("R3 contents kept", 8'h0E);

        // R10 register 8 via control port
        acc(1'b1, A_CTL_A, 8'h08);
        acc(1'b0, A_CTL_A, 8'h00);
        chk("R10 reg8 request", {a_rq, a_wr, a_ch, a_rg}, {1'b1, 1'b0, 1'b0, 4'd8});
        chk("R10 reg8 data", a_rd, 8'hA8);
        status_is("R10 FIFO untouched", 8'h0E);

        // R11 drain
        tx_ready = 1'b1;
        for (int i = 0; i < 40 && tx_valid; i++) @(negedge clk);
        tx_ready = 1'b0;
        chk("R11 drained count", drained, 16);
        chk("R11 scoreboard empty", txq.size(), 0);
        status_is("R11 tx empty after drain", 8'h09);

        // R12 receive with overrun
        for (int i = 0; i < 20; i++) send_rx(8'h80 + 8'(i), 1'b1);
        status_is("R12 rx full and overrun", 8'h71);

        // R8 pop
        for (int i = 0; i < 16; i++) begin
            acc(1'b0, A_DAT_A, 8'h00);
            chk("R8 rx pop order", a_rd, rxq.pop_front());
            rxm--;
        end
        acc(1'b0, A_DAT_A, 8'h00);
        chk("R8 empty read value", a_rd, 8'h00);
        chk("R8 empty read no request", a_rq, 1'b0);
        status_is("R12 overrun sticky", 8'h49);

        // R9 channel B data while on
        acc(1'b0, A_DAT_B, 8'h00);
        chk("R9 data B on", {a_rq, a_ch, a_rg}, {1'b1, 1'b1, 4'd8});
        chk("R9 data B read", a_rd, 8'hB8);

        // R11 off means no offer; R2 resets
        push_tx(8'h21); push_tx(8'h22); push_tx(8'h23);
        acc(1'b1, A_FCR, 8'h00);
        #1;
        chk("R11 tx_valid off", tx_valid, 1'b0);
        acc(1'b0, A_DAT_A, 8'h00);
        chk("R9 off data A read", {a_rq, a_ch, a_rg}, {1'b1, 1'b0, 4'd8});
        acc(1'b1, A_FCR, 8'h02);
        chk("R13 reset write no request", a_rq, 1'b0);
        acc(1'b0, A_FCR, 8'h00);
        chk("R2 tx reset bit readback", a_rd, 8'h02);
        status_is("R2 tx cleared", 8'h49);
        txq.delete(); txm = 0;
        acc(1'b1, A_FCR, 8'h04);
        status_is("R2 rx reset clears overrun", 8'h09);
        acc(1'b1, A_FCR, 8'h00);

        // R12 ignored while off
        send_rx(8'h55, 1'b0);
        status_is("R12 off rx ignored", 8'h09);

        // R1 card reset
        acc(1'b1, A_FCR, 8'h01);
        push_tx(8'h31); push_tx(8'h32);
        acc(1'b1, A_CTL_A, 8'h07);
        card_rst = 1'b1;
        @(negedge clk);
        card_rst = 1'b0;
        txq.delete(); txm = 0;
        acc(1'b0, A_FCR, 8'h00);
        chk("R1 card reset ctrl", a_rd, 8'h00);
        status_is("R1 card reset status", 8'h09);
        acc(1'b0, A_CTL_A, 8'h00);
        chk("R1 card reset pointer", {a_rq, a_rg}, {1'b1, 4'd0});

        repeat (3) @(negedge clk);
        report();
        $finish;
    end
endmodule